// File: doc/BRIEF.md
# Flash Program Pulse Sequencer

This block runs the timed control sequence that programs one 128-byte unit of on-chip flash. A single start request raises the write-enable strobe. The block then loops through programming passes. Each pass raises the setup strobe, applies a program pulse, releases pulse and setup in turn, and opens a verify window. At the end of that window it samples an externally computed verify-pass flag. The flash array and the data comparison sit outside the block. The block only produces the strobes and sequences them.

The program pulse width depends on the pass number: a short pulse on the early passes and a long one after that. On each early pass, the verify step is followed by a brief reinforcing pulse, flagged on its own output, that rewrites the bits already programmed. The block finishes in one of two ways. If verify passes, it ends with a one-cycle done pulse. If the pass limit is reached without a pass, it ends with a one-cycle fail pulse. In both cases write-enable is dropped first and a fixed recovery interval elapses before the pulse. Every interval is given in microseconds and converted to clock cycles, rounded up, from a clock-rate parameter in kHz. Verify time never counts toward the pulse-time budget.

Top module: `flash_pgm_seq`

## Requirements
- R1: While reset is asserted and immediately after it, every strobe, `reinf_o`, `busy_o`, `done_o` and `fail_o` is low.
- R2: A `start_i` seen while idle raises `swe_o` and `busy_o`. Each program pulse `pls_o` is high only while `psu_o` and `swe_o` are high. `psu_o` has been high for exactly ceil(T_PSU_US·CLK_KHZ/1000) cycles (minimum 1) when `pls_o` rises.
- R3: On main passes 1 to EXTRA_PASSES, the program pulse lasts ceil(T_SHORT_US·CLK_KHZ/1000) cycles.
- R4: On main passes EXTRA_PASSES+1 to MAX_PASSES, the program pulse lasts ceil(T_LONG_US·CLK_KHZ/1000) cycles.
- R5: After the verify window of each of passes 1 to EXTRA_PASSES, one reinforcing pulse with `reinf_o` high is applied, lasting ceil(T_ADD_US·CLK_KHZ/1000) cycles. Later passes get none.
- R6: `verify_ok_i` is sampled on the last cycle of the `pv_o` window. A high sample ends the operation with `done_o`, after exactly as many main pulses as the pass in which verify first held.
- R7: If verify has not held after MAX_PASSES main pulses, the operation ends with `fail_o` and no further pulse.
- R8: From the cycle `swe_o` falls at the end, exactly ceil(T_SWEOFF_US·CLK_KHZ/1000) cycles pass before `done_o`/`fail_o`. That pulse is one cycle long, the two are never high together, and `busy_o` is low on the following cycle.
- R9: `start_i` while `busy_o` is high has no effect: the running operation's pulse count and result are unchanged, and the block stays idle after it ends.
- R10: The verify strobe `pv_o` is never high together with `psu_o`. Each verify window lasts ceil(T_PV_US·CLK_KHZ/1000) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one programming operation (taken only when idle) |
| verify_ok_i | input | 1 | Result of the external verify comparison |
| swe_o | output | 1 | Write-enable strobe |
| psu_o | output | 1 | Program setup strobe |
| pls_o | output | 1 | Program pulse strobe |
| pv_o | output | 1 | Program verify strobe |
| reinf_o | output | 1 | High during a reinforcing (additional-write) step |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: programming succeeded |
| fail_o | output | 1 | One-cycle pulse: pass limit reached without verify |

## Verification
The hardest case to reach from the ports is the boundary between the early and late passes. There, the pulse width switches and the reinforcing step stops. A fail needs every pass up to the limit to run. The bench shrinks the clock-rate and pass-limit parameters so that a whole late-pass sequence fits in a short run. A bench model of the external verify raises `verify_ok_i` only once a chosen number of main pulses has been seen. The directed targets sit on pass 1, the last early pass, the first late pass, the limit, and beyond the limit. Random targets and extra start requests issued mid-operation fill in the rest.

// File: rtl/fps_pkg.sv
package fps_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SWE_ON,
      ST_PSU_ON,
      ST_PULSE,
      ST_P_OFF,
      ST_PSU_OFF,
      ST_PV_ON,
      ST_PV_OFF,
      ST_SWE_OFF,
      ST_REPORT
   } fps_state_e;

   // microseconds to clock cycles, rounded up, never below one cycle
   function automatic int unsigned us2cyc(input int unsigned us, input int unsigned khz);
      longint unsigned t;
      t = (longint'(us) * longint'(khz) + 64'd999) / 64'd1000;
      if (t < 64'd1) t = 64'd1;
      return int'(t);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fps_wait_timer.sv
module fps_wait_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R2: a loaded wait counts down by one each cycle
   a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fps_pass_ctr.sv
module fps_pass_ctr #(
   parameter int MAX_PASSES   = 1000,
   parameter int EXTRA_PASSES = 6,
   localparam int PW = $clog2(MAX_PASSES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic first_i,
   input  logic next_i,
   output logic early_o,
   output logic last_o
);

   logic [PW-1:0] pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pass_q <= '0;
      else if (first_i) pass_q <= PW'(1);
      else if (next_i)  pass_q <= pass_q + 1'b1;
   end

   assign last_o = (pass_q == PW'(MAX_PASSES));

   generate
      if (EXTRA_PASSES > 0) begin : g_early
         assign early_o = (pass_q <= PW'(EXTRA_PASSES));
      end else begin : g_no_early
         assign early_o = 1'b0;
      end
   endgenerate

   // R7: the pass number never goes past the limit
   a_r7_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_q <= PW'(MAX_PASSES)));
   a_r7_no_step_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (next_i |-> !last_o));

endmodule

// File: rtl/fps_strobe_dec.sv
module fps_strobe_dec
   import fps_pkg::*;
(
   input  fps_state_e st_i,
   input  logic       reinf_i,
   input  logic       ok_i,
   output logic       swe_o,
   output logic       psu_o,
   output logic       pls_o,
   output logic       pv_o,
   output logic       reinf_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       fail_o
);

   logic in_pgm;

   always_comb begin
      in_pgm  = (st_i == ST_PSU_ON) || (st_i == ST_PULSE) ||
                (st_i == ST_P_OFF)  || (st_i == ST_PSU_OFF);
      swe_o   = in_pgm || (st_i == ST_SWE_ON) || (st_i == ST_PV_ON) || (st_i == ST_PV_OFF);
      psu_o   = (st_i == ST_PSU_ON) || (st_i == ST_PULSE) || (st_i == ST_P_OFF);
      pls_o   = (st_i == ST_PULSE);
      pv_o    = (st_i == ST_PV_ON);
      reinf_o = reinf_i && in_pgm;
      busy_o  = (st_i != ST_IDLE);
      done_o  = (st_i == ST_REPORT) && ok_i;
      fail_o  = (st_i == ST_REPORT) && !ok_i;
   end

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
   import fps_pkg::*;
#(
   parameter int unsigned CLK_KHZ      = 20000,
   parameter int          MAX_PASSES   = 1000,
   parameter int          EXTRA_PASSES = 6,
   parameter int unsigned T_SWE_US     = 1,
   parameter int unsigned T_PSU_US     = 50,
   parameter int unsigned T_SHORT_US   = 30,
   parameter int unsigned T_LONG_US    = 200,
   parameter int unsigned T_ADD_US     = 10,
   parameter int unsigned T_POFF_US    = 5,
   parameter int unsigned T_PSUOFF_US  = 5,
   parameter int unsigned T_PV_US      = 4,
   parameter int unsigned T_PVOFF_US   = 2,
   parameter int unsigned T_SWEOFF_US  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic verify_ok_i,
   output logic swe_o,
   output logic psu_o,
   output logic pls_o,
   output logic pv_o,
   output logic reinf_o,
   output logic busy_o,
   output logic done_o,
   output logic fail_o
);

   localparam int unsigned D_SWE    = us2cyc(T_SWE_US, CLK_KHZ);
   localparam int unsigned D_PSU    = us2cyc(T_PSU_US, CLK_KHZ);
   localparam int unsigned D_SHORT  = us2cyc(T_SHORT_US, CLK_KHZ);
   localparam int unsigned D_LONG   = us2cyc(T_LONG_US, CLK_KHZ);
   localparam int unsigned D_ADD    = us2cyc(T_ADD_US, CLK_KHZ);
   localparam int unsigned D_POFF   = us2cyc(T_POFF_US, CLK_KHZ);
   localparam int unsigned D_PSUOFF = us2cyc(T_PSUOFF_US, CLK_KHZ);
   localparam int unsigned D_PV     = us2cyc(T_PV_US, CLK_KHZ);
   localparam int unsigned D_PVOFF  = us2cyc(T_PVOFF_US, CLK_KHZ);
   localparam int unsigned D_SWEOFF = us2cyc(T_SWEOFF_US, CLK_KHZ);
   localparam int unsigned DMAX =
      max2(max2(max2(D_SWE, D_PSU), max2(D_SHORT, D_LONG)),
           max2(max2(D_ADD, D_POFF), max2(max2(D_PSUOFF, D_PV), max2(D_PVOFF, D_SWEOFF))));
   localparam int TW = $clog2(DMAX + 1);

   generate
      if (CLK_KHZ < 1 || MAX_PASSES < 1 || EXTRA_PASSES < 0 || EXTRA_PASSES > MAX_PASSES) begin : g_bad_cfg
         $error("flash_pgm_seq: illegal parameter combination");
      end
   endgenerate

   fps_state_e    st_q, st_d;
   logic          reinf_q, reinf_d;
   logic          vok_q;
   logic          t_zero, t_load;
   logic [TW-1:0] t_val;
   logic          p_first, p_next, p_early, p_last;
   logic          decide;

   fps_wait_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .zero_o(t_zero)
   );

   fps_pass_ctr #(.MAX_PASSES(MAX_PASSES), .EXTRA_PASSES(EXTRA_PASSES)) u_pass (
      .clk(clk), .rst_n(rst_n), .first_i(p_first), .next_i(p_next),
      .early_o(p_early), .last_o(p_last)
   );

   always_comb begin
      st_d    = st_q;
      reinf_d = reinf_q;
      t_load  = 1'b0;
      t_val   = '0;
      p_first = 1'b0;
      p_next  = 1'b0;
      decide  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start_i) begin
            st_d = ST_SWE_ON; t_load = 1'b1; t_val = TW'(D_SWE - 1);
            p_first = 1'b1; reinf_d = 1'b0;
         end
         ST_SWE_ON: if (t_zero) begin
            st_d = ST_PSU_ON; t_load = 1'b1; t_val = TW'(D_PSU - 1);
         end
         ST_PSU_ON: if (t_zero) begin
            st_d = ST_PULSE; t_load = 1'b1;
            if (reinf_q)      t_val = TW'(D_ADD - 1);
            else if (p_early) t_val = TW'(D_SHORT - 1);
            else              t_val = TW'(D_LONG - 1);
         end
         ST_PULSE: if (t_zero) begin
            st_d = ST_P_OFF; t_load = 1'b1; t_val = TW'(D_POFF - 1);
         end
         ST_P_OFF: if (t_zero) begin
            st_d = ST_PSU_OFF; t_load = 1'b1; t_val = TW'(D_PSUOFF - 1);
         end
         ST_PSU_OFF: if (t_zero) begin
            if (reinf_q) decide = 1'b1;
            else begin
               st_d = ST_PV_ON; t_load = 1'b1; t_val = TW'(D_PV - 1);
            end
         end
         ST_PV_ON: if (t_zero) begin
            st_d = ST_PV_OFF; t_load = 1'b1; t_val = TW'(D_PVOFF - 1);
         end
         ST_PV_OFF: if (t_zero) begin
            if (p_early) begin
               st_d = ST_PSU_ON; t_load = 1'b1; t_val = TW'(D_PSU - 1); reinf_d = 1'b1;
            end else decide = 1'b1;
         end
         ST_SWE_OFF: if (t_zero) st_d = ST_REPORT;
         ST_REPORT:  st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
      if (decide) begin
         t_load = 1'b1;
         if (vok_q || p_last) begin
            st_d = ST_SWE_OFF; t_val = TW'(D_SWEOFF - 1);
         end else begin
            st_d = ST_PSU_ON; t_val = TW'(D_PSU - 1); reinf_d = 1'b0; p_next = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         reinf_q <= 1'b0;
         vok_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         reinf_q <= reinf_d;
         if (st_q == ST_IDLE && start_i)      vok_q <= 1'b0;
         else if (st_q == ST_PV_ON && t_zero) vok_q <= verify_ok_i;
      end
   end

   fps_strobe_dec u_dec (
      .st_i(st_q), .reinf_i(reinf_q), .ok_i(vok_q),
      .swe_o(swe_o), .psu_o(psu_o), .pls_o(pls_o), .pv_o(pv_o), .reinf_o(reinf_o),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
   );

   // R2: a pulse only under setup and write-enable
   a_r2_pulse_needs_setup: assert property (@(posedge clk) disable iff (!rst_n)
      pls_o |-> (psu_o && swe_o));
   // R10: verify and setup never overlap
   a_r10_verify_excl: assert property (@(posedge clk) disable iff (!rst_n)
      pv_o |-> !psu_o);
   // R8: result pulses are exclusive and followed by idle
   a_r8_result_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fail_o));
   a_r8_report_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |=> !busy_o);
   // R8: write-enable is low when a result is reported
   a_r8_swe_low_at_report: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |-> !swe_o);
   // R9: an operation in progress keeps running whatever start does
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && !fail_o) |=> busy_o);
   // R5: reinforcing step only on early passes
   a_r5_reinf_early: assert property (@(posedge clk) disable iff (!rst_n)
      reinf_o |-> p_early);

endmodule

// File: tb/sim_flash_pgm_seq.sv
`timescale 1ns/1ps
module sim_flash_pgm_seq;

   localparam int KHZ   = 200;
   localparam int MAXP  = 9;
   localparam int EXTRA = 6;

   function automatic int cyc(input int us);
      int t;
      t = (us * KHZ + 999) / 1000;
      return (t < 1) ? 1 : t;
   endfunction

   localparam int E_PSU    = (50 * KHZ + 999) / 1000;
   localparam int E_SHORT  = (30 * KHZ + 999) / 1000;
   localparam int E_LONG   = (200 * KHZ + 999) / 1000;
   localparam int E_ADD    = (10 * KHZ + 999) / 1000;
   localparam int E_PV     = 1;
   localparam int E_SWEOFF = (100 * KHZ + 999) / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic verify_ok_i;
   logic swe_o, psu_o, pls_o, pv_o, reinf_o, busy_o, done_o, fail_o;

   always #2.5 clk = ~clk;

   flash_pgm_seq #(.CLK_KHZ(KHZ), .MAX_PASSES(MAXP), .EXTRA_PASSES(EXTRA)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .verify_ok_i(verify_ok_i),
      .swe_o(swe_o), .psu_o(psu_o), .pls_o(pls_o), .pv_o(pv_o), .reinf_o(reinf_o),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
   );

   int checks = 0, failures = 0;
   int k_target = 1000;
   int main_cnt = 0, reinf_cnt = 0, pw = 0, pre = 0, pvw = 0, swoff = 0;
   int reports = 0, cycles = 0;
   logic prev_pls = 1'b0, prev_pv = 1'b0, prev_busy = 1'b0, pls_reinf = 1'b0;
   bit finished = 0;

   assign verify_ok_i = (main_cnt >= k_target);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_width(input int n, input logic rf);
      if (rf) return E_ADD;
      return (n <= EXTRA) ? E_SHORT : E_LONG;
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // monitor: all sampling on the falling edge
   always @(negedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1;
         chk(1'b0, "watchdog", cycles, 150000);
         finish_run();
      end
      if (rst_n) begin
         if (busy_o && !prev_busy) begin
            main_cnt = 0; reinf_cnt = 0; swoff = 0; pre = 0; pvw = 0;
         end
         if (pls_o && !prev_pls) begin
            chk(pre == E_PSU, "R2 setup before pulse", pre, E_PSU);
            chk(psu_o && swe_o, "R2 pulse under setup", int'(psu_o && swe_o), 1);
            pls_reinf = reinf_o;
            if (reinf_o) reinf_cnt++; else main_cnt++;
            pw = 1;
         end else if (pls_o) pw++;
         if (!pls_o && prev_pls) begin
            if (pls_reinf)
               chk(pw == exp_width(main_cnt, 1'b1), "R5 reinforcing width", pw, exp_width(main_cnt, 1'b1));
            else if (main_cnt <= EXTRA)
               chk(pw == exp_width(main_cnt, 1'b0), "R3 early pulse width", pw, exp_width(main_cnt, 1'b0));
            else
               chk(pw == exp_width(main_cnt, 1'b0), "R4 late pulse width", pw, exp_width(main_cnt, 1'b0));
         end
         if (psu_o && !pls_o) pre++;
         else if (!psu_o) pre = 0;
         if (pv_o) pvw++;
         if (!pv_o && prev_pv) begin
            chk(pvw == E_PV, "R10 verify window", pvw, E_PV);
            pvw = 0;
         end
         if (busy_o && !swe_o && !done_o && !fail_o) swoff++;
         if (done_o || fail_o) begin
            automatic int ep = (k_target <= MAXP) ? k_target : MAXP;
            automatic int er = (ep < EXTRA) ? ep : EXTRA;
            if (k_target <= MAXP) begin
               chk(done_o && !fail_o, "R6 done on verify", int'(done_o), 1);
               chk(main_cnt == ep, "R6 main pulse count", main_cnt, ep);
            end else begin
               chk(fail_o && !done_o, "R7 fail at limit", int'(fail_o), 1);
               chk(main_cnt == MAXP, "R7 main pulse count", main_cnt, MAXP);
            end
            chk(reinf_cnt == er, "R5 reinforcing count", reinf_cnt, er);
            chk(swoff == E_SWEOFF, "R8 recovery gap", swoff, E_SWEOFF);
            reports++;
         end
      end
      prev_pls  = pls_o;
      prev_pv   = pv_o;
      prev_busy = busy_o;
   end

   task automatic run_op(input int k, input int poke);
      automatic int r0 = reports;
      k_target = k;
      @(posedge clk); #1 start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
      @(negedge clk);
      chk(busy_o && swe_o, "R2 start accepted", int'(busy_o && swe_o), 1);
      if (poke > 0) begin
         repeat (poke) @(posedge clk);
         #1 start_i = 1'b1;   // R9: start while busy
         @(posedge clk); #1 start_i = 1'b0;
      end
      while (reports == r0) @(negedge clk);
      @(negedge clk);
      chk(!busy_o && !done_o && !fail_o, "R8 one-cycle result", int'(busy_o || done_o || fail_o), 0);
      repeat (3) @(negedge clk);
      chk(!busy_o && !swe_o, "R9 no restart after busy start", int'(busy_o || swe_o), 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk({swe_o, psu_o, pls_o, pv_o, reinf_o, busy_o, done_o, fail_o} == 8'h00,
          "R1 outputs in reset", int'({swe_o, psu_o, pls_o, pv_o, reinf_o, busy_o, done_o, fail_o}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !swe_o && !done_o && !fail_o, "R1 idle after reset", int'(busy_o || swe_o), 0);
      if (cyc(1) != 1) chk(1'b0, "R2 ceiling", cyc(1), 1);
      // directed corners
      run_op(1, 0);
      run_op(EXTRA, 7);
      run_op(EXTRA + 1, 0);
      run_op(MAXP, 30);
      run_op(MAXP + 1, 0);
      run_op(MAXP + 5, 12);
      // random targets, some beyond the limit
      for (int i = 0; i < 10; i++) begin
         automatic int k = 1 + int'($urandom_range(MAXP + 1, 0));
         automatic int p = int'($urandom_range(60, 0));
         run_op(k, p);
      end
      finished = 1;
      finish_run();
   end

endmodule